// File: doc/BRIEF.md
# Sixteen-bit Arithmetic and Logic Unit with Condition Flags

This block evaluates one of thirteen operations on two 16-bit operands, chosen by a 4-bit operation code. It returns a 16-bit result and four condition flags: zero, negative, carry and signed overflow. Addition, subtraction, the bitwise operations and single-bit shifts finish in one cycle. Unsigned multiplication gives either the low or the high word of the product. Unsigned division gives either the quotient or the remainder. These four operations run as iterative engines that handle one operand bit per cycle.

The caller raises `start` for one cycle with the operation code and operands valid. The block copies what it needs at that edge. `busy` stays high while an iterative operation runs, and a start request in that time is ignored. Each completed operation raises `done` for one cycle. The result and flags are updated in that same cycle and hold until the next operation completes.

Top module: `alu16_core`

## Requirements
- R1: Code 0 gives A+B and code 1 gives A-B, both modulo 2^16. For addition, carry is the unsigned carry out. For subtraction, carry is set when A < B as unsigned values (borrow). For both, overflow is set when the signed result is out of range.
- R2: Codes 2, 3, 4 and 5 give A AND B, A OR B, A XOR B and NOT A. Carry and overflow are cleared.
- R3: Code 6 shifts A left by one and sets carry to A bit 15. Code 7 shifts A right by one, filling with zero. Code 8 shifts A right by one, keeping bit 15. For codes 7 and 8, carry is A bit 0. Overflow is cleared for all three.
- R4: Code 9 gives the low 16 bits of the unsigned product A*B, with carry set when the high 16 bits are nonzero. Code 10 gives the high 16 bits, with carry cleared. Overflow is cleared for both.
- R5: With B nonzero, code 11 gives the unsigned quotient A/B and code 12 gives the unsigned remainder A mod B. Carry and overflow are cleared.
- R6: With B zero, code 11 gives 0xFFFF and code 12 gives A. Both set overflow.
- R7: For every operation, zero is set exactly when the result is 0, and negative equals result bit 15.
- R8: Codes 13, 14 and 15 give a result of 0 with zero set and negative, carry and overflow cleared.
- R9: For codes other than 9 to 12, a start sampled at edge k makes `done` high and the result valid right after edge k. `busy` stays low.
- R10: For codes 9 to 12, `busy` is high from the start edge k until edge k+17. The result and `done` appear right after edge k+17, and `busy` drops at that edge.
- R11: A start while `busy` is high is ignored. The result and flags change only in a cycle where `done` is high.
- R12: While reset is asserted, the result, all flags, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation with the present code and operands |
| op | input | 4 | Operation code |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| result | output | 16 | Result of the last completed operation |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 15 |
| flag_c | output | 1 | Carry, borrow, shifted-out bit or high-word-nonzero |
| flag_v | output | 1 | Signed overflow, or division by zero |
| busy | output | 1 | Iterative operation in progress |
| done | output | 1 | Result and flags updated this cycle |

## Verification
Directed operands target each flag's boundary. Examples are 0xFFFF+1 (carry with zero), 0x7FFF+1 (signed overflow without carry), 0-1 and 0x8000-1 (borrow against overflow), a 0x8001 shift that separates the outgoing bit from the kept sign, and a full-scale multiply whose high word is nonzero. Division by zero, with a quotient and remainder that differ, is set against ordinary division to show the zero-divisor path. Back-to-back single-cycle requests with `start` held high show that every cycle completes an operation. Keeping `start` asserted with new operands during a multiply shows that the copied operands are used and the extra requests are dropped. Random operations, including the unused codes, cover the remaining combinations.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam logic [3:0] OP_ADD   = 4'd0;
  localparam logic [3:0] OP_SUB   = 4'd1;
  localparam logic [3:0] OP_AND   = 4'd2;
  localparam logic [3:0] OP_OR    = 4'd3;
  localparam logic [3:0] OP_XOR   = 4'd4;
  localparam logic [3:0] OP_NOT   = 4'd5;
  localparam logic [3:0] OP_SHL   = 4'd6;
  localparam logic [3:0] OP_SHR   = 4'd7;
  localparam logic [3:0] OP_SAR   = 4'd8;
  localparam logic [3:0] OP_MULLO = 4'd9;
  localparam logic [3:0] OP_MULHI = 4'd10;
  localparam logic [3:0] OP_DIV   = 4'd11;
  localparam logic [3:0] OP_REM   = 4'd12;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } alu_flags_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } ctl_state_e;

  // Codes served by the bit-serial engines.
  function automatic logic is_iterative(input logic [3:0] code);
    return (code == OP_MULLO) || (code == OP_MULHI) ||
           (code == OP_DIV)   || (code == OP_REM);
  endfunction

endpackage

// File: rtl/alu16_quick.sv
module alu16_quick
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output alu_flags_t   flags
);

  // Width-extended sum; the top bit is the carry out.
  function automatic logic [W:0] sum_ext(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  // Width-extended difference; the top bit is the borrow.
  function automatic logic [W:0] diff_ext(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction

  logic [W:0] add_w;
  logic [W:0] sub_w;

  always_comb begin
    add_w   = sum_ext(a, b);
    sub_w   = diff_ext(a, b);
    res     = '0;
    flags.c = 1'b0;
    flags.v = 1'b0;
    case (op)
      OP_ADD: begin
        res     = add_w[W-1:0];
        flags.c = add_w[W];
        flags.v = (a[W-1] == b[W-1]) && (add_w[W-1] != a[W-1]);
      end
      OP_SUB: begin
        res     = sub_w[W-1:0];
        flags.c = sub_w[W];
        flags.v = (a[W-1] != b[W-1]) && (sub_w[W-1] != a[W-1]);
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_NOT: res = ~a;
      OP_SHL: begin
        res     = {a[W-2:0], 1'b0};
        flags.c = a[W-1];
      end
      OP_SHR: begin
        res     = {1'b0, a[W-1:1]};
        flags.c = a[0];
      end
      OP_SAR: begin
        res     = {a[W-1], a[W-1:1]};
        flags.c = a[0];
      end
      default: res = '0;
    endcase
    flags.z = (res == '0);
    flags.n = res[W-1];
  end

endmodule

// File: rtl/alu16_mul.sv
module alu16_mul #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);

  logic [W-1:0] hi_q;
  logic [W-1:0] lo_q;
  logic [W-1:0] mcand_q;
  logic [W:0]   psum;

  // Add the multiplicand when the current multiplier bit is one.
  always_comb psum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      mcand_q <= '0;
    end else if (load) begin
      hi_q    <= '0;
      lo_q    <= a;
      mcand_q <= b;
    end else if (step) begin
      hi_q <= psum[W:1];
      lo_q <= {psum[0], lo_q[W-1:1]};
    end
  end

  assign prod_hi = hi_q;
  assign prod_lo = lo_q;

endmodule

// File: rtl/alu16_div.sv
module alu16_div #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);

  logic [W-1:0] rem_q;
  logic [W-1:0] quo_q;
  logic [W-1:0] dvs_q;
  logic [W:0]   trial;
  logic         fits;
  logic [W:0]   rem_nxt;

  // Restoring step. A zero divisor always fits, so the quotient fills with
  // ones and the remainder collects the dividend.
  always_comb begin
    trial   = {rem_q, quo_q[W-1]};
    fits    = (trial >= {1'b0, dvs_q});
    rem_nxt = fits ? (trial - {1'b0, dvs_q}) : trial;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= a;
      dvs_q <= b;
    end else if (step) begin
      rem_q <= rem_nxt[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         flag_z,
  output logic         flag_n,
  output logic         flag_c,
  output logic         flag_v,
  output logic         busy,
  output logic         done
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  ctl_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]   op_q;
  logic         bzero_q;

  // Named internal events, also visible to the bound checker.
  logic launch;
  logic launch_fast;
  logic launch_iter;
  logic step_en;
  logic iter_last;
  logic commit_iter;

  logic [W-1:0] q_res;
  alu_flags_t   q_flags;
  logic [W-1:0] mul_hi;
  logic [W-1:0] mul_lo;
  logic [W-1:0] div_quo;
  logic [W-1:0] div_rem;
  logic [W-1:0] i_res;
  alu_flags_t   i_flags;
  alu_flags_t   flags_q;

  assign launch      = start && (state_q == ST_IDLE);
  assign launch_fast = launch && !is_iterative(op);
  assign launch_iter = launch && is_iterative(op);
  assign step_en     = (state_q == ST_RUN);
  assign iter_last   = step_en && (cnt_q == LAST_STEP);
  assign commit_iter = (state_q == ST_FIN);

  alu16_quick #(.W(W)) u_quick (
    .op    (op),
    .a     (a),
    .b     (b),
    .res   (q_res),
    .flags (q_flags)
  );

  alu16_mul #(.W(W)) u_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (launch_iter),
    .step    (step_en),
    .a       (a),
    .b       (b),
    .prod_hi (mul_hi),
    .prod_lo (mul_lo)
  );

  alu16_div #(.W(W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (launch_iter),
    .step  (step_en),
    .a     (a),
    .b     (b),
    .quo   (div_quo),
    .rem   (div_rem)
  );

  // Select the engine output for the operation captured at launch.
  always_comb begin
    i_res     = '0;
    i_flags.c = 1'b0;
    i_flags.v = 1'b0;
    case (op_q)
      OP_MULLO: begin
        i_res     = mul_lo;
        i_flags.c = |mul_hi;
      end
      OP_MULHI: i_res = mul_hi;
      OP_DIV: begin
        i_res     = div_quo;
        i_flags.v = bzero_q;
      end
      OP_REM: begin
        i_res     = div_rem;
        i_flags.v = bzero_q;
      end
      default: i_res = '0;
    endcase
    i_flags.z = (i_res == '0);
    i_flags.n = i_res[W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_q    <= '0;
      bzero_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (launch_iter) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
          op_q    <= op;
          bzero_q <= (b == '0);
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (iter_last) state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      flags_q <= '0;
      done    <= 1'b0;
    end else begin
      done <= launch_fast || commit_iter;
      if (launch_fast) begin
        result  <= q_res;
        flags_q <= q_flags;
      end else if (commit_iter) begin
        result  <= i_res;
        flags_q <= i_flags;
      end
    end
  end

  assign flag_z = flags_q.z;
  assign flag_n = flags_q.n;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;
  assign busy   = (state_q != ST_IDLE);

endmodule

// File: rtl/alu16_checker.sv
module alu16_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result,
  input logic         flag_z,
  input logic         flag_n,
  input logic         flag_c,
  input logic         flag_v,
  input logic         launch_fast,
  input logic         launch_iter
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW+1:0] ITER_LAT = (CW + 2)'(W + 1);

  logic          track_q;
  logic [CW+1:0] lat_q;

  // Cycle count since the last iterative launch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      track_q <= 1'b0;
      lat_q   <= '0;
    end else if (launch_iter) begin
      track_q <= 1'b1;
      lat_q   <= '0;
    end else if (done) begin
      track_q <= 1'b0;
    end else if (track_q) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_z == (result == '0))); // R7

  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_n == result[W-1])); // R7

  AST_LOGIC_CV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_fast && (op >= 4'd2) && (op <= 4'd5)) |=> (!flag_c && !flag_v)); // R2

  AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_fast && (op >= 4'd13)) |=> ((result == '0) && flag_z && !flag_n && !flag_c && !flag_v)); // R8

  AST_FAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    launch_fast |=> (done && !busy)); // R9

  AST_ITER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    launch_iter |=> (busy && !done)); // R10

  AST_ITER_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (track_q && done) |-> (lat_q == ITER_LAT)); // R10

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

  AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!launch_fast && !launch_iter)); // R11

  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(flag_z) && $stable(flag_n) &&
               $stable(flag_c) && $stable(flag_v))); // R11

endmodule

bind alu16_core alu16_checker #(.W(W)) u_alu16_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .op          (op),
  .busy        (busy),
  .done        (done),
  .result      (result),
  .flag_z      (flag_z),
  .flag_n      (flag_n),
  .flag_c      (flag_c),
  .flag_v      (flag_v),
  .launch_fast (launch_fast),
  .launch_iter (launch_iter)
);

// File: tb/test_alu16_core.sv
module test_alu16_core;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int MASK       = 'hFFFF;
  localparam int SIGN       = 'h8000;
  localparam int ITER_LAT   = W + 1;
  localparam int WATCHDOG   = 150000;

  logic         clk   = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   op    = '0;
  logic [W-1:0] a     = '0;
  logic [W-1:0] b     = '0;
  wire  [W-1:0] result;
  wire          flag_z, flag_n, flag_c, flag_v, busy, done;

  alu16_core #(.W(W)) i_alu16_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op     (op),
    .a      (a),
    .b      (b),
    .result (result),
    .flag_z (flag_z),
    .flag_n (flag_n),
    .flag_c (flag_c),
    .flag_v (flag_v),
    .busy   (busy),
    .done   (done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int vectors     = 0;
  int miscompares = 0;

  // Reference model state: outputs expected after the next edge.
  int    m_res   = 0;
  bit    m_z = 1'b0, m_n = 1'b0, m_c = 1'b0, m_v = 1'b0;
  bit    m_done  = 1'b0;
  bit    m_busy  = 1'b0;
  int    m_count = 0;
  string m_tag   = "R12";
  int    p_res   = 0;
  bit    p_z = 1'b0, p_n = 1'b0, p_c = 1'b0, p_v = 1'b0;
  string p_tag   = "R10";

  function automatic string tag_of(input int o, input int y);
    if (o <= 1)  return "R1";
    if (o <= 5)  return "R2";
    if (o <= 8)  return "R3";
    if (o <= 10) return "R4";
    if (o <= 12) return (y == 0) ? "R6" : "R5";
    return "R8";
  endfunction

  task automatic ref_op(input int o, input int x, input int y,
                        output int r, output bit z, output bit n, output bit c, output bit v);
    longint p;
    p = longint'(x) * longint'(y);
    r = 0; c = 1'b0; v = 1'b0;
    case (o)
      0: begin
        r = x + y;
        c = (r > MASK);
        r = r & MASK;
        v = (((x ^ y) & SIGN) == 0) && (((x ^ r) & SIGN) != 0);
      end
      1: begin
        c = (x < y);
        r = (x - y) & MASK;
        v = (((x ^ y) & SIGN) != 0) && (((x ^ r) & SIGN) != 0);
      end
      2: r = x & y;
      3: r = x | y;
      4: r = x ^ y;
      5: r = (~x) & MASK;
      6: begin r = (x * 2) & MASK; c = ((x & SIGN) != 0); end
      7: begin r = x / 2; c = ((x & 1) != 0); end
      8: begin r = (x / 2) | (x & SIGN); c = ((x & 1) != 0); end
      9: begin r = int'(p & longint'(MASK)); c = ((p / 65536) != 0); end
      10: r = int'(p / 65536);
      11: if (y == 0) begin r = MASK; v = 1'b1; end else r = x / y;
      12: if (y == 0) begin r = x;    v = 1'b1; end else r = x % y;
      default: r = 0;
    endcase
    z = (r == 0);
    n = ((r & SIGN) != 0);
  endtask

  // Compare on every falling edge, then advance the model with the inputs
  // that the next rising edge will sample.
  always @(negedge clk) begin
    string tg;
    vectors++;
    if (!rst_n) begin
      m_res = 0; m_z = 1'b0; m_n = 1'b0; m_c = 1'b0; m_v = 1'b0;
      m_done = 1'b0; m_busy = 1'b0; m_count = 0; m_tag = "R12";
      if (result !== '0 || {flag_z, flag_n, flag_c, flag_v} !== 4'b0 || busy !== 1'b0 || done !== 1'b0) begin
        miscompares++;
        $display("FAIL R12 reset: result=%h znc v=%b busy=%b done=%b expected all zero",
                 result, {flag_z, flag_n, flag_c, flag_v}, busy, done);
      end
    end else begin
      tg = m_tag;
      if ({flag_z, flag_n} !== {m_z, m_n}) tg = "R7";
      if (result !== W'(m_res) || {flag_z, flag_n, flag_c, flag_v} !== {m_z, m_n, m_c, m_v} ||
          done !== m_done || busy !== m_busy) begin
        miscompares++;
        $display("FAIL %s: result=%h zncv=%b done=%b busy=%b expected result=%h zncv=%b done=%b busy=%b",
                 tg, result, {flag_z, flag_n, flag_c, flag_v}, done, busy,
                 W'(m_res), {m_z, m_n, m_c, m_v}, m_done, m_busy);
      end
      m_done = 1'b0;
      if (m_count > 0) begin
        m_count--;
        if (start) m_tag = "R11";
        if (m_count == 0) begin
          m_res = p_res; m_z = p_z; m_n = p_n; m_c = p_c; m_v = p_v;
          m_done = 1'b1; m_busy = 1'b0; m_tag = p_tag;
        end
      end else if (start) begin
        if (op >= 4'd9 && op <= 4'd12) begin
          ref_op(int'(op), int'(a), int'(b), p_res, p_z, p_n, p_c, p_v);
          p_tag   = $sformatf("%s/R10", tag_of(int'(op), int'(b)));
          m_count = ITER_LAT;
          m_busy  = 1'b1;
          m_tag   = "R10";
        end else begin
          ref_op(int'(op), int'(a), int'(b), m_res, m_z, m_n, m_c, m_v);
          m_done = 1'b1;
          m_tag  = $sformatf("%s/R9", tag_of(int'(op), int'(b)));
        end
      end
    end
  end

  task automatic drive(input int o, input int x, input int y);
    @(posedge clk);
    #1;
    start = 1'b1;
    op    = 4'(o);
    a     = W'(x);
    b     = W'(y);
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
    start = 1'b0;
    for (int i = 0; i < 40 && busy; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic run(input int o, input int x, input int y);
    drive(o, x, y);
    settle();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    $display("FAIL R10 watchdog: run still active after %0d cycles, expected to finish", WATCHDOG);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);                       // R12 checked while held
    #1 rst_n = 1'b1;
    // R1 carry, overflow and borrow corners
    run(0, 'hFFFF, 'h0001);
    run(0, 'h7FFF, 'h0001);
    run(0, 'h8000, 'h8000);
    run(1, 'h0000, 'h0001);
    run(1, 'h8000, 'h0001);
    run(1, 'h1234, 'h1234);
    // R2 logic with carry and overflow cleared
    run(2, 'hF0F0, 'h3C3C);
    run(3, 'h0000, 'h0000);
    run(4, 'hAAAA, 'hFFFF);
    run(5, 'hFFFF, 'h0000);
    // R3 shifts with outgoing bit in carry
    run(6, 'h8001, 0);
    run(7, 'h8001, 0);
    run(8, 'h8001, 0);
    run(8, 'h0001, 0);
    // R4 multiply low and high words
    run(9, 'hFFFF, 'hFFFF);
    run(10, 'hFFFF, 'hFFFF);
    run(9, 'h0100, 'h0100);
    run(10, 'h0003, 'h0005);
    // R5 divide and remainder, R6 zero divisor
    run(11, 1000, 7);
    run(12, 1000, 7);
    run(11, 'h1234, 0);
    run(12, 'h1234, 0);
    run(11, 5, 9);
    // R8 unused codes
    run(13, 'hFFFF, 'hFFFF);
    run(14, 'h1234, 'h0001);
    run(15, 'h8000, 'h8000);
    // R9 back-to-back single-cycle requests
    for (int i = 0; i < 24; i++) begin
      int o;
      o = (i % 12 < 9) ? (i % 12) : 13 + (i % 3);
      drive(o, $urandom_range(0, MASK), $urandom_range(0, MASK));
    end
    settle();
    // R11 requests while a multiply runs are dropped
    drive(9, 'h1234, 'h5678);
    for (int i = 0; i < 12; i++) drive(i % 9, $urandom_range(0, MASK), $urandom_range(0, MASK));
    settle();
    drive(11, 'hBEEF, 'h0013);
    for (int i = 0; i < 20; i++) drive(12, $urandom_range(0, MASK), 0);
    settle();
    // Random mix including zero divisors and unused codes
    for (int i = 0; i < 300; i++) begin
      int o, x, y;
      o = $urandom_range(0, 15);
      x = $urandom_range(0, MASK);
      y = ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(0, MASK);
      if (i % 3 == 0) drive(o, x, y);
      else run(o, x, y);
    end
    settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    finish_run();
  end

endmodule